// File: doc/BRIEF.md
# Embedded Interval, Fixed-Period and Watchdog Timer Unit

This block holds three timers that share a single tick-enable input. A free-running tick counter acts as the time base. A fixed-period timer fires every time that counter reaches a multiple of a selectable power of two. A programmable down-counter fires once its loaded interval has run out, and it can reload itself to run again. A staged watchdog, driven by the same time base, escalates on each expiry: first it arms, then it interrupts, and finally it asks for a reset of a programmed kind.

Software owns a 10-bit-wide control word, placed in bits 31:22 of a 32-bit write port. It also owns a status word in bits 31:26, cleared by writing ones, and a separate write port for the down-counter's reload value. The unit drives three interrupt requests and a one-cycle reset request that carries a 2-bit reset kind. The reset sequencing that follows the request belongs to other logic.

Period exponents are parameters. With the defaults, the fixed-period timer selects 2^9, 2^13, 2^17 or 2^21 ticks and the watchdog selects 2^17, 2^21, 2^25 or 2^29 ticks. Each option is `BASE + STEP*sel`.

Top module: `tmr_unit`

## Requirements
- R1: After a synchronous reset, the control word, the status word, the down-counter value, the time base, all three interrupts and the reset request are zero.
- R2: A control write stores bits 31:22 of the data, and `ctrl_o` returns them in the same positions. Bits 21:0 of `ctrl_o` always read zero.
- R3: A reload write loads both the reload value and the down-counter. After that, the down-counter drops by one on each tick, but only while the reload value is greater than 1 and control bit 26 is set. Otherwise it holds its value.
- R4: If a tick arrives while the down-counter is running at value 1, status bit 27 is set. The counter then reloads if control bit 22 is set; if not, it goes to 0 and stays stopped until the next reload write.
- R5: The time base advances once per tick. On each tick that brings it to a multiple of 2^(FIT_BASE+FIT_STEP*s), status bit 26 is set, where s is control bits 25:24.
- R6: Watchdog expiries happen on each tick that brings the time base to a multiple of 2^(WDG_BASE+WDG_STEP*w), where w is control bits 31:30.
- R7: At a watchdog expiry, the current status bits 31:30 decide the action. If bit 31 is clear, bit 31 is set. If bit 31 is set and bit 30 is clear, bit 30 is set. Every expiry leaves the watchdog running for the next period.
- R8: At an expiry that finds status bits 31:30 both set, control bits 29:28 are copied into status bits 29:28. If that field is nonzero (1 core, 2 chip, 3 system), `rst_req_o` pulses for exactly one cycle with `rst_kind_o` equal to it. A field of 0 produces no request.
- R9: The interrupt outputs are formed as follows:
  - `pit_irq_o` = status bit 27 AND control bit 26.
  - `fit_irq_o` = status bit 26 AND control bit 23.
  - `wdg_irq_o` = status bit 30 AND control bit 27.
- R10: A status write clears each of bits 31:26 whose data bit is 1. An event that sets a bit in the same cycle wins. Status bits 25:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base advance enable, one tick per cycle when high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control write data (bits 31:22 used) |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 32 | Ones clear status bits 31:26 |
| rld_we | input | 1 | Down-counter reload write strobe |
| rld_wdata | input | PIT_W | Reload value |
| ctrl_o | output | 32 | Current control word |
| stat_o | output | 32 | Current status word |
| pit_cnt_o | output | PIT_W | Current down-counter value |
| pit_irq_o | output | 1 | Interval timer interrupt request |
| fit_irq_o | output | 1 | Fixed-period interrupt request |
| wdg_irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_kind_o | output | 2 | Kind of reset requested |

## Verification
Faults in internal state show up at different ports, and with different delays:
- **Time base.** A wrong count shifts every fixed-period and watchdog event. Status bit 26 then appears a tick early or late, and the bench checks it on the exact tick where it should rise.
- **Down-counter.** A wrong armed flag or count can be seen on `pit_cnt_o` right after the next tick. Examples are counting while disabled, or restarting without auto-reload.
- **Watchdog stage.** A stage decoded from the wrong status bits shows a full period later. It appears as a missing or early bit in status bits 31:28, or as a reset pulse that is missing, repeated or of the wrong kind.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control field layout, bits 31:22 of the control word, MSB first
    typedef struct packed {
        logic [1:0] wdg_sel;    // 31:30 watchdog period select
        logic [1:0] rst_kind;   // 29:28 reset action at final stage
        logic       wdg_ie;     // 27    watchdog interrupt enable
        logic       pit_ie;     // 26    interval timer enable and interrupt enable
        logic [1:0] fit_sel;    // 25:24 fixed-period select
        logic       fit_ie;     // 23    fixed-period interrupt enable
        logic       pit_auto;   // 22    interval timer auto-reload
    } ctrl_t;

    // Status field layout, bits 31:26 of the status word, MSB first
    typedef struct packed {
        logic       wdg_armed;  // 31 first watchdog stage
        logic       wdg_int;    // 30 second watchdog stage
        logic [1:0] rst_seen;   // 29:28 copy of reset action taken
        logic       pit_int;    // 27 interval expiry
        logic       fit_int;    // 26 fixed-period expiry
    } stat_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CORE = 2'd1,
        RK_CHIP = 2'd2,
        RK_SYS  = 2'd3
    } rst_kind_e;

    localparam int CTRL_LSB = 22;
    localparam int STAT_LSB = 26;

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        return {c, {CTRL_LSB{1'b0}}};
    endfunction

    function automatic logic [31:0] stat_word(input stat_t s);
        return {s, {STAT_LSB{1'b0}}};
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int TB_W = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    output logic [TB_W-1:0] tb_nxt
);
    logic [TB_W-1:0] tb_q;

    assign tb_nxt = tb_q + TB_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       tb_q <= '0;
        else if (tick) tb_q <= tb_nxt;
    end
endmodule

// File: rtl/tmr_tap.sv
module tmr_tap #(
    parameter int TB_W = 30,
    parameter int BASE = 9,
    parameter int STEP = 4
) (
    input  logic            tick,
    input  logic [TB_W-1:0] tb_nxt,
    input  logic [1:0]      sel,
    output logic            hit
);
    logic [3:0] cand;

    for (genvar i = 0; i < 4; i++) begin : g_opt
        localparam int SH = BASE + STEP * i;
        assign cand[i] = (tb_nxt[SH-1:0] == '0);
    end

    assign hit = tick & cand[sel];
endmodule

// File: rtl/tmr_pit.sv
module tmr_pit #(
    parameter int PIT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [PIT_W-1:0] load_val,
    input  logic             ie,
    input  logic             pit_auto,
    output logic [PIT_W-1:0] cnt,
    output logic             expire
);
    logic [PIT_W-1:0] cnt_q;
    logic [PIT_W-1:0] rld_q;
    logic             armed_q;
    logic             run;
    logic             step;

    assign run    = armed_q && (rld_q > PIT_W'(1)) && ie;
    assign step   = tick && run;
    assign expire = step && (cnt_q == PIT_W'(1));
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rld_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            rld_q   <= load_val;
            armed_q <= 1'b1;
        end else if (expire) begin
            if (pit_auto) begin
                cnt_q <= rld_q;
            end else begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end
        end else if (step) begin
            cnt_q <= cnt_q - PIT_W'(1);
        end
    end

    // R4: a one-shot expiry leaves the counter at zero
    a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (expire && !pit_auto && !load) |=> (cnt_q == '0));

    // R3: no count change without a running tick or a load
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_wdg.sv
module tmr_wdg (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       armed,
    input  logic       intr,
    input  logic [1:0] kind,
    output logic       set_armed,
    output logic       set_int,
    output logic       fire,
    output logic       rst_req,
    output logic [1:0] rst_kind
);
    import tmr_pkg::*;

    logic       req_q;
    logic [1:0] kind_q;

    assign set_armed = hit && !armed;
    assign set_int   = hit && armed && !intr;
    assign fire      = hit && armed && intr;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            kind_q <= RK_NONE;
        end else begin
            req_q  <= fire && (kind != RK_NONE);
            kind_q <= fire ? kind : RK_NONE;
        end
    end

    assign rst_req  = req_q;
    assign rst_kind = kind_q;

    // R8: request lasts one cycle and always names a real reset
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);
    a_r8_kind_nonzero: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (kind_q != RK_NONE));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int PIT_W    = 32,
    parameter int FIT_BASE = 9,
    parameter int FIT_STEP = 4,
    parameter int WDG_BASE = 17,
    parameter int WDG_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    input  logic             stat_clr_we,
    input  logic [31:0]      stat_clr_data,
    input  logic             rld_we,
    input  logic [PIT_W-1:0] rld_wdata,
    output logic [31:0]      ctrl_o,
    output logic [31:0]      stat_o,
    output logic [PIT_W-1:0] pit_cnt_o,
    output logic             pit_irq_o,
    output logic             fit_irq_o,
    output logic             wdg_irq_o,
    output logic             rst_req_o,
    output logic [1:0]       rst_kind_o
);
    import tmr_pkg::*;

    localparam int FIT_TOP = FIT_BASE + 3 * FIT_STEP;
    localparam int WDG_TOP = WDG_BASE + 3 * WDG_STEP;
    localparam int TB_W    = max2(FIT_TOP, WDG_TOP) + 1;

    ctrl_t           ctrl_q;
    stat_t           stat_q;
    stat_t           stat_d;
    logic [TB_W-1:0] tb_nxt;
    logic            fit_hit;
    logic            wdg_hit;
    logic            pit_exp;
    logic            wdg_set_armed;
    logic            wdg_set_int;
    logic            wdg_fire;

    tmr_timebase #(.TB_W(TB_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .tb_nxt (tb_nxt)
    );

    tmr_tap #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit_tap (
        .tick   (tick),
        .tb_nxt (tb_nxt),
        .sel    (ctrl_q.fit_sel),
        .hit    (fit_hit)
    );

    tmr_tap #(.TB_W(TB_W), .BASE(WDG_BASE), .STEP(WDG_STEP)) u_wdg_tap (
        .tick   (tick),
        .tb_nxt (tb_nxt),
        .sel    (ctrl_q.wdg_sel),
        .hit    (wdg_hit)
    );

    tmr_pit #(.PIT_W(PIT_W)) u_pit (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (rld_we),
        .load_val (rld_wdata),
        .ie       (ctrl_q.pit_ie),
        .pit_auto (ctrl_q.pit_auto),
        .cnt      (pit_cnt_o),
        .expire   (pit_exp)
    );

    tmr_wdg u_wdg (
        .clk       (clk),
        .rst       (rst),
        .hit       (wdg_hit),
        .armed     (stat_q.wdg_armed),
        .intr      (stat_q.wdg_int),
        .kind      (ctrl_q.rst_kind),
        .set_armed (wdg_set_armed),
        .set_int   (wdg_set_int),
        .fire      (wdg_fire),
        .rst_req   (rst_req_o),
        .rst_kind  (rst_kind_o)
    );

    // Status: clear first, then hardware events override
    always_comb begin
        stat_d = stat_q;
        if (stat_clr_we) stat_d = stat_d & ~stat_t'(stat_clr_data[31:STAT_LSB]);
        if (fit_hit)       stat_d.fit_int   = 1'b1;
        if (pit_exp)       stat_d.pit_int   = 1'b1;
        if (wdg_set_armed) stat_d.wdg_armed = 1'b1;
        if (wdg_set_int)   stat_d.wdg_int   = 1'b1;
        if (wdg_fire)      stat_d.rst_seen  = ctrl_q.rst_kind;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata[31:CTRL_LSB]);
            stat_q <= stat_d;
        end
    end

    assign ctrl_o    = ctrl_word(ctrl_q);
    assign stat_o    = stat_word(stat_q);
    assign pit_irq_o = stat_q.pit_int & ctrl_q.pit_ie;
    assign fit_irq_o = stat_q.fit_int & ctrl_q.fit_ie;
    assign wdg_irq_o = stat_q.wdg_int & ctrl_q.wdg_ie;

    // R7: second stage only follows an armed first stage
    a_r7_int_after_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.wdg_int) |-> $past(stat_q.wdg_armed));

    // R5: a fixed-period hit is recorded in status
    a_r5_fit_recorded: assert property (@(posedge clk) disable iff (rst)
        fit_hit |=> stat_q.fit_int);

    // R10: a clear without a competing event takes effect
    a_r10_w1c_fit: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_we && stat_clr_data[26] && !fit_hit) |=> !stat_q.fit_int);

    // R4: an interval expiry is recorded in status
    a_r4_pit_recorded: assert property (@(posedge clk) disable iff (rst)
        pit_exp |=> stat_q.pit_int);
endmodule

// File: tb/tmr_unit_test.sv
module tmr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        stat_clr_we = 1'b0;
    logic [31:0] stat_clr_data = '0;
    logic        rld_we = 1'b0;
    logic [31:0] rld_wdata = '0;
    logic [31:0] ctrl_o, stat_o, pit_cnt_o;
    logic        pit_irq_o, fit_irq_o, wdg_irq_o, rst_req_o;
    logic [1:0]  rst_kind_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // Bench periods: fixed-period 4/8/16/32 ticks, watchdog 16/32/64/128 ticks
    tmr_unit #(.PIT_W(32), .FIT_BASE(2), .FIT_STEP(1), .WDG_BASE(4), .WDG_STEP(1)) uut (
        .clk(clk), .rst(rst), .tick(tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .rld_we(rld_we), .rld_wdata(rld_wdata),
        .ctrl_o(ctrl_o), .stat_o(stat_o), .pit_cnt_o(pit_cnt_o),
        .pit_irq_o(pit_irq_o), .fit_irq_o(fit_irq_o), .wdg_irq_o(wdg_irq_o),
        .rst_req_o(rst_req_o), .rst_kind_o(rst_kind_o)
    );

    localparam logic [1:0] OP_CTRL = 2'd0, OP_RLD = 2'd1, OP_CLR = 2'd2, OP_TICK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] arg;
        logic [31:0] exp_stat;   // checked under mask bits 27:26
        logic [2:0]  exp_irq;    // {wdg, fit, pit}
        logic [31:0] exp_cnt;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{OP_RLD,  32'd5,           32'h0000_0000, 3'b000, 32'd5}, // R3 loaded, not enabled
        '{OP_TICK, 32'd3,           32'h0000_0000, 3'b000, 32'd5}, // R3 holds while bit 26 clear
        '{OP_CTRL, 32'h0480_0000,   32'h0000_0000, 3'b000, 32'd5}, // R2 enable interval, fit irq
        '{OP_TICK, 32'd1,           32'h0400_0000, 3'b010, 32'd4}, // R5 hit at 4, R3 counts
        '{OP_CLR,  32'h0400_0000,   32'h0000_0000, 3'b000, 32'd4}, // R10 clear
        '{OP_TICK, 32'd3,           32'h0000_0000, 3'b000, 32'd1}, // R3
        '{OP_TICK, 32'd1,           32'h0C00_0000, 3'b011, 32'd0}, // R4 one-shot expiry, R5 at 8
        '{OP_TICK, 32'd2,           32'h0C00_0000, 3'b011, 32'd0}, // R4 stays stopped
        '{OP_CLR,  32'h0C00_0000,   32'h0000_0000, 3'b000, 32'd0}, // R10
        '{OP_CTRL, 32'h05C0_0000,   32'h0000_0000, 3'b000, 32'd0}, // R2 auto-reload, fit sel 1
        '{OP_RLD,  32'd3,           32'h0000_0000, 3'b000, 32'd3}, // R3 load
        '{OP_TICK, 32'd3,           32'h0800_0000, 3'b001, 32'd3}, // R4 reload after expiry
        '{OP_CLR,  32'h0800_0000,   32'h0000_0000, 3'b000, 32'd3}, // R10
        '{OP_TICK, 32'd3,           32'h0C00_0000, 3'b011, 32'd3}, // R4 second period, R5 at 16
        '{OP_CLR,  32'h0C00_0000,   32'h0000_0000, 3'b000, 32'd3}, // R10
        '{OP_RLD,  32'd1,           32'h0000_0000, 3'b000, 32'd1}, // R3 reload of 1
        '{OP_TICK, 32'd2,           32'h0000_0000, 3'b000, 32'd1}, // R3 stopped at 1
        '{OP_CTRL, 32'h0000_0000,   32'h0000_0000, 3'b000, 32'd1}, // R9 enables off
        '{OP_TICK, 32'd2,           32'h0400_0000, 3'b000, 32'd1}, // R9 status set, irq masked
        '{OP_CTRL, 32'h0080_0000,   32'h0400_0000, 3'b010, 32'd1}  // R9 enabling shows irq
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_rld(input logic [31:0] v);
        @(negedge clk); rld_we = 1'b1; rld_wdata = v;
        @(negedge clk); rld_we = 1'b0;
    endtask

    task automatic clr_stat(input logic [31:0] v);
        @(negedge clk); stat_clr_we = 1'b1; stat_clr_data = v;
        @(negedge clk); stat_clr_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ctrl", ctrl_o, 32'h0);
        chk("R1 stat", stat_o, 32'h0);
        chk("R1 cnt", pit_cnt_o, 32'h0);
        chk("R1 outs", {27'b0, wdg_irq_o, fit_irq_o, pit_irq_o, rst_req_o, 1'b0}, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_CTRL: wr_ctrl(VECS[i].arg);
                OP_RLD:  wr_rld(VECS[i].arg);
                OP_CLR:  clr_stat(VECS[i].arg);
                default: ticks(int'(VECS[i].arg));
            endcase
            chk($sformatf("vec%0d R4/R5/R10 stat", i), stat_o & 32'h0C00_0000, VECS[i].exp_stat);
            chk($sformatf("vec%0d R9 irq", i), {29'b0, wdg_irq_o, fit_irq_o, pit_irq_o}, {29'b0, VECS[i].exp_irq});
            chk($sformatf("vec%0d R3 cnt", i), pit_cnt_o, VECS[i].exp_cnt);
        end

        // R2 unused control bits read zero
        do_reset();
        wr_ctrl(32'hFFFF_FFFF);
        chk("R2 ctrl mask", ctrl_o, 32'hFFC0_0000);
        chk("R10 stat low bits", stat_o & 32'h03FF_FFFF, 32'h0);

        // R7/R8 escalation: wdg period 16, irq on, chip reset
        do_reset();
        wr_ctrl(32'h2800_0000);
        ticks(15);
        chk("R6 before period", stat_o[31:28], 4'h0);
        ticks(1);
        chk("R7 stage one", stat_o[31:28], 4'h8);
        chk("R9 wdg irq off at stage one", wdg_irq_o, 1'b0);
        ticks(16);
        chk("R7 stage two", stat_o[31:28], 4'hC);
        chk("R9 wdg irq", wdg_irq_o, 1'b1);
        chk("R8 no early reset", rst_req_o, 1'b0);
        ticks(15);
        chk("R8 still no reset", rst_req_o, 1'b0);
        ticks(1);
        chk("R8 reset req", rst_req_o, 1'b1);
        chk("R8 reset kind", rst_kind_o, 2'd2);
        chk("R8 kind copied", stat_o[31:28], 4'hE);
        @(negedge clk);
        chk("R8 one cycle", rst_req_o, 1'b0);
        clr_stat(32'h8000_0000);
        chk("R10 clear stage one", stat_o[31:28], 4'h6);
        ticks(16);
        chk("R7 rearm after clear", stat_o[31:28], 4'hE);
        chk("R7 no reset on rearm", rst_req_o, 1'b0);

        // R6 period select 1 = 32 ticks
        do_reset();
        wr_ctrl(32'h4000_0000);
        ticks(16);
        chk("R6 sel1 not at 16", stat_o[31], 1'b0);
        ticks(16);
        chk("R6 sel1 at 32", stat_o[31], 1'b1);

        // R8 reset action none
        do_reset();
        wr_ctrl(32'h0000_0000);
        ticks(48);
        chk("R8 none no request", rst_req_o, 1'b0);
        chk("R8 none status", stat_o[31:28], 4'hC);

        summary();
        $finish;
    end
endmodule